// File: doc/BRIEF.md
# Disk Power Mode Controller

This block keeps track of which power mode a storage device is in: active, idle, standby or sleep. It takes the command decoder's one-cycle strobes for the power commands and for any command that reaches the media. It also takes the 8-bit inactivity byte that comes with the idle and standby commands, and a once-per-second tick. From these it drives the current mode, a request to keep the spindle turning, and a busy flag that covers the time a mode change takes.

The inactivity byte is turned into a timeout in seconds by a piecewise map. While the device is in active or idle mode and the timer is armed, each tick advances a counter. When the counter reaches the timeout, the device drops to standby. A media command wakes the device from standby. In sleep mode every strobe is ignored, and only reset brings the device back. After a media command the device leaves active mode for idle on its own after a short hold time.

Top module: `disk_pwr_ctrl`

## Requirements
- R1: After reset the mode is active, spin_req is 1 and busy is 0. The mode codes are 00 active, 01 idle, 10 standby and 11 sleep.
- R2: In active mode with busy low and no strobe arriving, the mode changes to idle after ACT_CYC (default 4) clock cycles.
- R3: An inactivity byte of 0 gives a timeout of 1800 ticks.
- R4: Inactivity bytes 1, 2 and 3 give a timeout of 15 ticks.
- R5: An inactivity byte from 4 to 240 gives a timeout of the byte value times 5 ticks.
- R6: An inactivity byte from 241 to 255 gives a timeout of 1200 ticks.
- R7: An accepted idle, idle-immediate, standby, standby-immediate or sleep strobe sets the target mode at the next edge and holds busy high for CHG_CYC (default 8) cycles. Idle and standby also load the byte, arm the timer and clear the counter. The two immediate forms leave the timer untouched.
- R8: When the armed counter reaches the timeout in active or idle mode, the mode becomes standby and spin_req falls, with no busy period.
- R9: The counter holds its value in standby and sleep. A media strobe restarts it from zero.
- R10: A media strobe in standby gives active mode with busy held for CHG_CYC cycles. In active or idle mode it gives active mode with no busy period.
- R11: In sleep mode every strobe and tick is ignored. Only reset leaves sleep.
- R12: Until an idle or standby command has loaded a byte after reset, ticks never cause standby.
- R13: spin_req is 1 in active and idle modes and 0 in standby and sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_idle | input | 1 | Idle command strobe (loads the byte) |
| cmd_idle_now | input | 1 | Idle-immediate command strobe |
| cmd_standby | input | 1 | Standby command strobe (loads the byte) |
| cmd_standby_now | input | 1 | Standby-immediate command strobe |
| cmd_sleep | input | 1 | Sleep command strobe |
| cmd_media | input | 1 | Media-access command strobe |
| timer_byte | input | 8 | Inactivity byte, sampled with cmd_idle or cmd_standby |
| tick_1s | input | 1 | One-second tick, one cycle wide |
| mode | output | 2 | Current power mode |
| spin_req | output | 1 | Spindle run request |
| busy | output | 1 | A mode change is in progress |

## Verification
The properties assume that at most one command strobe is high in any cycle and that strobes arrive only while busy is low, as a host that polls busy before issuing a command would do. The bench drives one strobe at a time. It waits out every busy window before the next command, and it raises the tick only in cycles with no strobe. This keeps each checked mode change tied to a single cause.

// File: rtl/pm_mode_pkg.sv
// Shared types for the disk power mode controller.
// Assumes nothing beyond a 2-bit mode code seen at the top ports.
package pm_mode_pkg;
    typedef enum logic [1:0] {
        PM_ACTIVE  = 2'b00,
        PM_IDLE    = 2'b01,
        PM_STANDBY = 2'b10,
        PM_SLEEP   = 2'b11
    } pm_mode_e;
endpackage

// File: rtl/pm_timeout_map.sv
// Turns the 8-bit inactivity byte into a timeout in seconds.
// Purely combinational. Assumes SEC_W is wide enough for ZERO_SEC and
// for RANGE_HI * STEP_SEC.
module pm_timeout_map #(
    parameter int SEC_W     = 11,
    parameter int ZERO_SEC  = 1800,
    parameter int SHORT_SEC = 15,
    parameter int STEP_SEC  = 5,
    parameter int RANGE_LO  = 4,
    parameter int RANGE_HI  = 240,
    parameter int CAP_SEC   = 1200
) (
    input  logic [7:0]       code,
    output logic [SEC_W-1:0] secs
);
    localparam logic [7:0] LO8 = 8'(RANGE_LO);
    localparam logic [7:0] HI8 = 8'(RANGE_HI);

    logic [SEC_W-1:0] scaled;

    // Linear part of the map: code times the step.
    always_comb scaled = SEC_W'(code) * SEC_W'(STEP_SEC);

    // Pick the piece of the map that the code falls into.
    always_comb begin
        if (code == 8'd0)
            secs = SEC_W'(ZERO_SEC);
        else if (code < LO8)
            secs = SEC_W'(SHORT_SEC);
        else if (code <= HI8)
            secs = scaled;
        else
            secs = SEC_W'(CAP_SEC);
    end
endmodule

// File: rtl/pm_idle_timer.sv
// Inactivity counter. Counts ticks up to a latched limit while run is high
// and raises expire in the cycle of the final tick.
// Assumes the limit is never zero and that load and restart are one-cycle strobes.
module pm_idle_timer #(
    parameter int SEC_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] limit_in,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    output logic             expire
);
    logic [SEC_W-1:0] limit_q;
    logic [SEC_W-1:0] cnt_q;
    logic             armed_q;

    // Expire on the tick that completes the timeout, unless the counter is being reset.
    always_comb expire = armed_q && run && tick && !load && !restart
                         && (cnt_q == limit_q - SEC_W'(1));

    // Hold the limit and the arm flag, and advance or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            limit_q <= limit_in;
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (armed_q && run && tick) begin
            cnt_q <= expire ? '0 : cnt_q + SEC_W'(1);
        end
    end
endmodule

// File: rtl/pm_busy_timer.sv
// Holds busy high for a fixed number of cycles after each start strobe.
// Assumes CHG_CYC >= 1.
module pm_busy_timer #(
    parameter int CHG_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int BW = $clog2(CHG_CYC + 1);

    logic [BW-1:0] cnt_q;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= BW'(CHG_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - BW'(1);
    end

    // Busy whenever the countdown is still running.
    always_comb busy = (cnt_q != '0);
endmodule

// File: rtl/pm_mode_fsm.sv
// Power mode state machine. Accepts strobes only when not busy and not asleep,
// picks the next mode by priority and drives the timer and busy controls.
// Assumes at most one strobe per cycle. Priority only resolves illegal overlaps.
module pm_mode_fsm
    import pm_mode_pkg::*;
#(
    parameter int ACT_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     c_idle,
    input  logic     c_idle_now,
    input  logic     c_stby,
    input  logic     c_stby_now,
    input  logic     c_sleep,
    input  logic     c_media,
    input  logic     expire,
    input  logic     busy,
    output pm_mode_e mode_q,
    output logic     load_limit,
    output logic     restart,
    output logic     start_busy,
    output logic     run
);
    localparam int AW = $clog2(ACT_CYC + 1);

    pm_mode_e      mode_d;
    logic [AW-1:0] acnt_q;
    logic          accept, go_idle, go_stby, go_sleep, media_ok, act_done;

    // Qualify the strobes: nothing is taken while busy or asleep.
    always_comb begin
        accept     = !busy && (mode_q != PM_SLEEP);
        go_idle    = accept && (c_idle || c_idle_now);
        go_stby    = accept && (c_stby || c_stby_now);
        go_sleep   = accept && c_sleep;
        media_ok   = accept && c_media;
        load_limit = accept && (c_idle || c_stby);
        restart    = media_ok;
        start_busy = go_idle || go_stby || go_sleep
                     || (media_ok && (mode_q == PM_STANDBY));
        run        = (mode_q == PM_ACTIVE) || (mode_q == PM_IDLE);
        act_done   = (mode_q == PM_ACTIVE) && !busy && (acnt_q == AW'(1));
    end

    // Next mode by priority: commands, then timer expiry, then the drop to idle.
    always_comb begin
        mode_d = mode_q;
        if (go_sleep)      mode_d = PM_SLEEP;
        else if (go_stby)  mode_d = PM_STANDBY;
        else if (go_idle)  mode_d = PM_IDLE;
        else if (media_ok) mode_d = PM_ACTIVE;
        else if (expire)   mode_d = PM_STANDBY;
        else if (act_done) mode_d = PM_IDLE;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= PM_ACTIVE;
        else        mode_q <= mode_d;
    end

    // Hold counter for active mode, reloaded by each media command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acnt_q <= AW'(ACT_CYC);
        else if (media_ok)
            acnt_q <= AW'(ACT_CYC);
        else if ((mode_q == PM_ACTIVE) && !busy && (acnt_q != '0))
            acnt_q <= acnt_q - AW'(1);
    end
endmodule

// File: rtl/disk_pwr_ctrl.sv
// Top level of the disk power mode controller. Wires together the timeout
// map, inactivity counter, busy timer and mode state machine.
// Assumes one-cycle strobes from a command decoder and a one-cycle tick.
module disk_pwr_ctrl
    import pm_mode_pkg::*;
#(
    parameter int ZERO_SEC  = 1800,
    parameter int SHORT_SEC = 15,
    parameter int STEP_SEC  = 5,
    parameter int CAP_SEC   = 1200,
    parameter int CHG_CYC   = 8,
    parameter int ACT_CYC   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_idle,
    input  logic       cmd_idle_now,
    input  logic       cmd_standby,
    input  logic       cmd_standby_now,
    input  logic       cmd_sleep,
    input  logic       cmd_media,
    input  logic [7:0] timer_byte,
    input  logic       tick_1s,
    output logic [1:0] mode,
    output logic       spin_req,
    output logic       busy
);
    localparam int SEC_W = $clog2(ZERO_SEC + 1);

    logic [SEC_W-1:0] limit_secs;
    logic             load_limit, restart, start_busy, run, expire, busy_w;
    pm_mode_e         mode_w;

    pm_timeout_map #(
        .SEC_W(SEC_W), .ZERO_SEC(ZERO_SEC), .SHORT_SEC(SHORT_SEC),
        .STEP_SEC(STEP_SEC), .RANGE_LO(4), .RANGE_HI(240), .CAP_SEC(CAP_SEC)
    ) u_map (
        .code(timer_byte),
        .secs(limit_secs)
    );

    pm_idle_timer #(.SEC_W(SEC_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load_limit), .limit_in(limit_secs),
        .restart(restart), .run(run), .tick(tick_1s), .expire(expire)
    );

    pm_busy_timer #(.CHG_CYC(CHG_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(start_busy), .busy(busy_w)
    );

    pm_mode_fsm #(.ACT_CYC(ACT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .c_idle(cmd_idle), .c_idle_now(cmd_idle_now),
        .c_stby(cmd_standby), .c_stby_now(cmd_standby_now),
        .c_sleep(cmd_sleep), .c_media(cmd_media),
        .expire(expire), .busy(busy_w), .mode_q(mode_w),
        .load_limit(load_limit), .restart(restart),
        .start_busy(start_busy), .run(run)
    );

    // Drive the outputs: mode code, spindle request from the running modes, busy.
    always_comb begin
        mode     = mode_w;
        spin_req = run;
        busy     = busy_w;
    end
endmodule

// File: rtl/pm_ctrl_chk.sv
// Property checker for disk_pwr_ctrl, attached by bind.
// Assumes at most one strobe per cycle.
module pm_ctrl_chk
    import pm_mode_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_idle,
    input logic       cmd_idle_now,
    input logic       cmd_standby,
    input logic       cmd_standby_now,
    input logic       cmd_sleep,
    input logic       cmd_media,
    input logic       tick_1s,
    input logic [1:0] mode,
    input logic       busy
);
    // R11
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_SLEEP) |=> (mode == PM_SLEEP));

    // R10
    wake_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_STANDBY && cmd_media && !busy && !cmd_sleep
         && !cmd_standby && !cmd_standby_now && !cmd_idle && !cmd_idle_now)
        |=> (mode == PM_ACTIVE && busy));

    // R7
    idle_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_idle_now && !busy && mode != PM_SLEEP && !cmd_sleep
         && !cmd_standby && !cmd_standby_now)
        |=> (mode == PM_IDLE && busy));

    // R8
    no_auto_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PM_STANDBY && !tick_1s && !cmd_standby && !cmd_standby_now)
        |=> (mode != PM_STANDBY));

    // R2
    act_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_IDLE && $past(mode) == PM_ACTIVE
         && !$past(cmd_idle) && !$past(cmd_idle_now))
        |-> !$past(busy));
endmodule

bind disk_pwr_ctrl pm_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .cmd_idle(cmd_idle), .cmd_idle_now(cmd_idle_now),
    .cmd_standby(cmd_standby), .cmd_standby_now(cmd_standby_now),
    .cmd_sleep(cmd_sleep), .cmd_media(cmd_media),
    .tick_1s(tick_1s), .mode(mode), .busy(busy)
);

// File: tb/disk_pwr_ctrl_test.sv
// Scoreboard bench for disk_pwr_ctrl: the driver pushes expected output sets,
// and the monitor compares them at the following falling edge.
module disk_pwr_ctrl_test;
    localparam logic [1:0] M_ACT = 2'b00, M_IDL = 2'b01, M_STB = 2'b10, M_SLP = 2'b11;
    localparam int S_IDLE = 0, S_IDLE_NOW = 1, S_STBY = 2, S_STBY_NOW = 3,
                   S_SLEEP = 4, S_MEDIA = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_idle = 0, cmd_idle_now = 0, cmd_standby = 0, cmd_standby_now = 0;
    logic cmd_sleep = 0, cmd_media = 0, tick_1s = 0;
    logic [7:0] timer_byte = '0;
    logic [1:0] mode;
    logic spin_req, busy;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic [1:0] m;
        logic       sp;
        logic       b;
        string      tag;
    } exp_t;
    exp_t sb[$];
    exp_t cur;

    always #2 clk = ~clk;

    disk_pwr_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_idle(cmd_idle), .cmd_idle_now(cmd_idle_now),
        .cmd_standby(cmd_standby), .cmd_standby_now(cmd_standby_now),
        .cmd_sleep(cmd_sleep), .cmd_media(cmd_media),
        .timer_byte(timer_byte), .tick_1s(tick_1s),
        .mode(mode), .spin_req(spin_req), .busy(busy)
    );

    // Monitor: compare every queued expectation with the outputs at the falling edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            cur = sb.pop_front();
            checks++;
            if (mode !== cur.m || spin_req !== cur.sp || busy !== cur.b) begin
                fails++;
                $display("FAIL %s: actual mode=%b spin=%b busy=%b expected mode=%b spin=%b busy=%b",
                         cur.tag, mode, spin_req, busy, cur.m, cur.sp, cur.b);
            end
        end
    end

    task automatic expect_out(input logic [1:0] m, input logic b, input string tag);
        exp_t e;
        e.m = m;
        e.sp = (m == M_ACT) || (m == M_IDL);   // R13
        e.b = b;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic strobe(input int which, input logic [7:0] code);
        timer_byte = code;
        case (which)
            S_IDLE:     cmd_idle = 1;
            S_IDLE_NOW: cmd_idle_now = 1;
            S_STBY:     cmd_standby = 1;
            S_STBY_NOW: cmd_standby_now = 1;
            S_SLEEP:    cmd_sleep = 1;
            default:    cmd_media = 1;
        endcase
        @(posedge clk);
        #1;
        cmd_idle = 0; cmd_idle_now = 0; cmd_standby = 0;
        cmd_standby_now = 0; cmd_sleep = 0; cmd_media = 0;
    endtask

    task automatic ticks(input int n);
        tick_1s = 1;
        repeat (n) @(posedge clk);
        #1;
        tick_1s = 0;
    endtask

    // Load a byte with the idle command, wait out busy, then step to one tick before expiry and to expiry.
    task automatic timeout_case(input logic [7:0] code, input int secs, input string tag);
        strobe(S_IDLE, code);
        expect_out(M_IDL, 1, {tag, " R7 load"});
        wait_cyc(8);
        ticks(secs - 1);
        expect_out(M_IDL, 0, {tag, " one tick short"});
        ticks(1);
        expect_out(M_STB, 0, {tag, " R8 expiry"});
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1;
        expect_out(M_ACT, 0, "R1 reset state");
        wait_cyc(10);
        expect_out(M_IDL, 0, "R2 auto idle after reset");
        ticks(2000);
        expect_out(M_IDL, 0, "R12 timer disarmed");

        // R4 and R7 busy window length
        strobe(S_IDLE, 8'd3);
        expect_out(M_IDL, 1, "R7 busy set");
        wait_cyc(7);
        expect_out(M_IDL, 1, "R7 busy still high");
        wait_cyc(1);
        expect_out(M_IDL, 0, "R7 busy cleared");
        ticks(14);
        expect_out(M_IDL, 0, "R4 one tick short");
        ticks(1);
        expect_out(M_STB, 0, "R4 R8 standby on expiry");

        // R10 wake from standby, then R2 drop to idle, R9 reload
        strobe(S_MEDIA, 8'd0);
        expect_out(M_ACT, 1, "R10 wake busy");
        wait_cyc(8);
        expect_out(M_ACT, 0, "R10 awake");
        wait_cyc(3);
        expect_out(M_ACT, 0, "R2 still active");
        wait_cyc(1);
        expect_out(M_IDL, 0, "R2 drop to idle");
        ticks(15);
        expect_out(M_STB, 0, "R9 count from wake");

        // R10 media in idle carries no busy; R9 restart
        strobe(S_IDLE, 8'd1);
        wait_cyc(8);
        ticks(10);
        strobe(S_MEDIA, 8'd0);
        expect_out(M_ACT, 0, "R10 media in idle");
        ticks(14);
        expect_out(M_IDL, 0, "R9 restarted count");
        ticks(1);
        expect_out(M_STB, 0, "R9 expiry after restart");

        // R5 via standby command then idle immediate
        strobe(S_STBY, 8'd4);
        expect_out(M_STB, 1, "R7 standby busy");
        wait_cyc(8);
        strobe(S_IDLE_NOW, 8'd0);
        expect_out(M_IDL, 1, "R7 idle immediate");
        wait_cyc(8);
        ticks(19);
        expect_out(M_IDL, 0, "R5 code 4 short");
        ticks(1);
        expect_out(M_STB, 0, "R5 code 4 expiry");

        timeout_case(8'd100, 500, "R5 code 100");
        timeout_case(8'd240, 1200, "R5 code 240");
        timeout_case(8'd241, 1200, "R6 code 241");
        timeout_case(8'd255, 1200, "R6 code 255");
        timeout_case(8'd0, 1800, "R3 code 0");

        // R9 counter holds in standby; immediate forms do not reload
        strobe(S_IDLE, 8'd1);
        wait_cyc(8);
        ticks(10);
        strobe(S_STBY_NOW, 8'd9);
        expect_out(M_STB, 1, "R7 standby immediate");
        wait_cyc(8);
        ticks(30);
        expect_out(M_STB, 0, "R9 held in standby");
        strobe(S_IDLE_NOW, 8'd9);
        wait_cyc(8);
        ticks(4);
        expect_out(M_IDL, 0, "R9 resumed count short");
        ticks(1);
        expect_out(M_STB, 0, "R9 resumed count expiry");

        // R11 sleep ignores everything
        strobe(S_SLEEP, 8'd0);
        expect_out(M_SLP, 1, "R11 sleep busy");
        wait_cyc(8);
        expect_out(M_SLP, 0, "R11 asleep");
        strobe(S_MEDIA, 8'd0);
        expect_out(M_SLP, 0, "R11 media ignored");
        strobe(S_IDLE, 8'd5);
        expect_out(M_SLP, 0, "R11 idle ignored");
        strobe(S_IDLE_NOW, 8'd0);
        expect_out(M_SLP, 0, "R11 idle immediate ignored");
        ticks(50);
        expect_out(M_SLP, 0, "R11 ticks ignored");

        // R11 and R1: reset leaves sleep; R12 timer disarmed again
        rst_n = 0;
        wait_cyc(2);
        rst_n = 1;
        expect_out(M_ACT, 0, "R1 reset out of sleep");
        ticks(100);
        expect_out(M_IDL, 0, "R12 disarmed after reset");

        @(negedge clk);
        #1;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule